// File: doc/BRIEF.md
# Two-Queue Conversion Command Sequencer

This block walks a 64-entry table of conversion commands and asks an external analog converter for one conversion per entry. Two queues share the table. The low queue always begins at entry 0. The high queue begins at a programmable split index. Every finished conversion stores its 10-bit result in a result table, at the same index as the command that produced it. Each command entry holds three things: a channel number, a sample-time code and a pause bit. When an entry with the pause bit set finishes, its queue stops and waits for its next trigger.

A host writes and reads the command table through a simple word port, and reads the result table through the same port. Each queue has its own enable and trigger input. The low queue has priority over the high queue. If the low queue is triggered while the high queue is converting, the high queue gives way once its current conversion is done. It continues later from its next entry. Each queue reports two sticky flags: one for a pause and one for end-of-queue.

Top module: `conv_queue_seq`

## Requirements
- R1: A host read of a command entry (address bit 6 = 0) returns the 10 stored bits in bits 9:0, and bits 15:10 always read 0. Write data in bits 15:10 is discarded.
- R2: A command entry has the channel in bits 5:0 and the sample-time code in bits 7:6. Bit 9 is the pause bit and bit 8 is kept as written. While `cnv_req` is high, `cnv_chan` and `cnv_stime` show the fields of the entry being converted.
- R3: On `cnv_done`, `cnv_result` is written to result entry i, where i is the index of the command being converted. A host read with address bit 6 = 1 returns result entry addr[5:0] in bits 9:0. Host writes to that half of the address space are ignored.
- R4: The low queue converts entries 0 up to `split_ptr`-1 in rising order, or up to 63 when `split_ptr` is 64 or more. After its last entry finishes, `q1_end_flag` is set.
- R5: The high queue converts entries `split_ptr` to 63 in rising order. After entry 63 finishes, `q2_end_flag` is set.
- R6: When an entry with the pause bit set finishes, its queue's pause flag is set and the queue stops. The next accepted trigger clears both of that queue's flags. The queue then continues at the following entry.
- R7: The low queue has priority. If it is triggered while the high queue is converting, the next conversion issued is the low queue's next entry. Once the low queue stops, the high queue continues at the entry after the last one it finished.
- R8: The sequencer never changes the command table. Only host writes change it.
- R9: A trigger has no effect in three cases: the queue is disabled, the queue is already running, or the queue is empty. The low queue is empty when `split_ptr` = 0. The high queue is empty when `split_ptr` >= 64.
- R10: After reset, `cnv_req` and all four flags are 0. `cnv_req` stays high with stable fields until the cycle in which `cnv_done` is high. It is then low for at least one cycle.
- R11: Clearing a queue's enable stops that queue. Its next accepted trigger starts it again from its first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 7 | Bit 6 selects result (1) or command (0) table; bits 5:0 are the entry |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from `host_addr` |
| q1_en | input | 1 | Low queue enable |
| q2_en | input | 1 | High queue enable |
| q1_trig | input | 1 | Low queue trigger, sampled each cycle |
| q2_trig | input | 1 | High queue trigger, sampled each cycle |
| split_ptr | input | 7 | First entry of the high queue |
| cnv_req | output | 1 | Conversion request |
| cnv_chan | output | 6 | Channel to convert |
| cnv_stime | output | 2 | Sample-time code |
| cnv_done | input | 1 | Converter finished, one-cycle pulse |
| cnv_result | input | 10 | Conversion result, valid with `cnv_done` |
| q1_pause_flag | output | 1 | Low queue stopped on a pause entry |
| q2_pause_flag | output | 1 | High queue stopped on a pause entry |
| q1_end_flag | output | 1 | Low queue reached its last entry |
| q2_end_flag | output | 1 | High queue reached entry 63 |

## Verification
A wrong queue pointer or arbitration decision shows up at the converter port on the very next request. The channel and sample-time fields would name the wrong entry, so the bench compares those fields every cycle against a behavioural model. A lost or misplaced result stays hidden until the result table is read back, so every slot is read at the end. A flag set too early or too late shows up in the cycle right after the retiring `cnv_done`.

// File: rtl/qseq_pkg.sv
// Shared widths and the command entry layout for the conversion sequencer.
// Assumes a 10-bit stored command and a 16-bit host word.
package qseq_pkg;
    localparam int CMD_W  = 10;
    localparam int RES_W  = 10;
    localparam int HOST_W = 16;
    localparam int CHAN_W = 6;
    localparam int ST_W   = 2;
    localparam int NQ     = 2;

    typedef struct packed {
        logic              pause;
        logic              rsvd;
        logic [ST_W-1:0]   stime;
        logic [CHAN_W-1:0] chan;
    } cmd_t;
endpackage

// File: rtl/qseq_tables.sv
// Command and result storage. The host writes commands only; results are
// written only by the retire port. Reads are combinational and zero-extended.
// Assumes CMD_W == RES_W <= HOST_W.
module qseq_tables
    import qseq_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W:0]    host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CMD_W-1:0]  rd_cmd,
    input  logic              res_we,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [RES_W-1:0]  res_data
);
    logic [CMD_W-1:0] cmd_mem [ENTRIES];
    logic [RES_W-1:0] res_mem [ENTRIES];

    // Command table: written from the host port only, low 10 bits kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) cmd_mem[i] <= '0;
        end else if (host_we && !host_addr[IDX_W]) begin
            cmd_mem[host_addr[IDX_W-1:0]] <= host_wdata[CMD_W-1:0];
        end
    end

    // Result table: written from the retiring conversion only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) res_mem[i] <= '0;
        end else if (res_we) begin
            res_mem[res_idx] <= res_data;
        end
    end

    // Host read mux with the unimplemented upper bits forced to zero.
    always_comb begin
        host_rdata = '0;
        if (host_addr[IDX_W])
            host_rdata[RES_W-1:0] = res_mem[host_addr[IDX_W-1:0]];
        else
            host_rdata[CMD_W-1:0] = cmd_mem[host_addr[IDX_W-1:0]];
    end

    // Dispatch read port.
    always_comb rd_cmd = cmd_mem[rd_idx];
endmodule

// File: rtl/qseq_queue.sv
// State of one queue: running bit, next-entry pointer, a resume marker for
// pauses taken mid-queue, and the sticky pause/end flags.
// Assumes start/end stay constant while the queue runs.
module qseq_queue #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig,
    input  logic             empty,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] end_idx,
    input  logic             retire,
    input  logic             retire_pause,
    input  logic [IDX_W-1:0] retire_idx,
    output logic             active,
    output logic [IDX_W-1:0] ptr,
    output logic             pause_flag,
    output logic             end_flag
);
    logic resume;

    // Trigger acceptance, retire bookkeeping, then disable override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            ptr        <= '0;
            resume     <= 1'b0;
            pause_flag <= 1'b0;
            end_flag   <= 1'b0;
        end else begin
            if (trig && en && !active && !empty) begin
                active     <= 1'b1;
                pause_flag <= 1'b0;
                end_flag   <= 1'b0;
                resume     <= 1'b0;
                if (!resume) ptr <= start_idx;
            end
            if (retire) begin
                if (retire_idx == end_idx) begin
                    active   <= 1'b0;
                    end_flag <= 1'b1;
                    resume   <= 1'b0;
                    if (retire_pause) pause_flag <= 1'b1;
                end else begin
                    ptr <= retire_idx + IDX_W'(1);
                    if (retire_pause) begin
                        active     <= 1'b0;
                        pause_flag <= 1'b1;
                        resume     <= 1'b1;
                    end
                end
            end
            if (!en) begin
                active <= 1'b0;
                resume <= 1'b0;
            end
        end
    end

    // R4 / R5: a running queue points inside its own span.
    p_ptr_in_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (ptr >= start_idx && ptr <= end_idx));

    // R6: a new pause flag means the queue has stopped.
    p_pause_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_flag) |-> !active);

    // R5: a new end flag means the queue has stopped.
    p_end_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> !active);
endmodule

// File: rtl/qseq_dispatch.sv
// Picks the ready queue (low queue first), captures its command at issue,
// holds the converter request until done and produces the retire strobes.
// Assumes the converter pulses cnv_done for exactly one cycle per request.
module qseq_dispatch
    import qseq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NQ-1:0]             q_ready,
    input  logic [NQ-1:0][IDX_W-1:0]  q_ptr,
    output logic [IDX_W-1:0]          rd_idx,
    input  cmd_t                      rd_cmd,
    input  logic                      cnv_done,
    input  logic [RES_W-1:0]          cnv_result,
    output logic                      cnv_req,
    output logic [CHAN_W-1:0]         cnv_chan,
    output logic [ST_W-1:0]           cnv_stime,
    output logic [NQ-1:0]             grant,
    output logic [NQ-1:0]             retire,
    output logic                      retire_pause,
    output logic [IDX_W-1:0]          retire_idx,
    output logic                      res_we,
    output logic [RES_W-1:0]          res_data
);
    logic       busy;
    logic       cur_q;
    logic       sel_q;
    cmd_t       cur_cmd;
    logic [IDX_W-1:0] cur_idx;

    // Fixed priority: the low queue wins whenever it is ready.
    always_comb begin
        sel_q  = !q_ready[0];
        rd_idx = q_ptr[sel_q];
        grant  = '0;
        if (!busy && |q_ready) grant[sel_q] = 1'b1;
    end

    // Issue and retire state of the single outstanding conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur_q   <= 1'b0;
            cur_idx <= '0;
            cur_cmd <= '0;
        end else if (busy && cnv_done) begin
            busy <= 1'b0;
        end else if (|grant) begin
            busy    <= 1'b1;
            cur_q   <= sel_q;
            cur_idx <= rd_idx;
            cur_cmd <= rd_cmd;
        end
    end

    // Retire strobes toward the owning queue and the result table.
    always_comb begin
        res_we       = busy && cnv_done;
        retire       = '0;
        retire[cur_q] = res_we;
        retire_pause = cur_cmd.pause;
        retire_idx   = cur_idx;
        res_data     = cnv_result;
    end

    assign cnv_req   = busy;
    assign cnv_chan  = cur_cmd.chan;
    assign cnv_stime = cur_cmd.stime;

    // R10: request held with stable fields until done.
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_req && !cnv_done) |=> (cnv_req && $stable(cnv_chan) && $stable(cnv_stime)));

    // R10: one idle cycle follows every completed conversion.
    p_gap_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_req && cnv_done) |=> !cnv_req);
endmodule

// File: rtl/conv_queue_seq.sv
// Top of the two-queue conversion sequencer: derives each queue's span from
// the split pointer, instantiates the queues, the dispatcher and the tables.
// Assumes ENTRIES is a power of two.
module conv_queue_seq
    import qseq_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W:0]    host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              q1_en,
    input  logic              q2_en,
    input  logic              q1_trig,
    input  logic              q2_trig,
    input  logic [IDX_W:0]    split_ptr,
    output logic              cnv_req,
    output logic [CHAN_W-1:0] cnv_chan,
    output logic [ST_W-1:0]   cnv_stime,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_result,
    output logic              q1_pause_flag,
    output logic              q2_pause_flag,
    output logic              q1_end_flag,
    output logic              q2_end_flag
);
    logic [NQ-1:0]            q_en, q_trig, q_empty, q_active, q_ready;
    logic [NQ-1:0]            q_pflag, q_eflag, retire, grant;
    logic [NQ-1:0][IDX_W-1:0] q_start, q_end, q_ptr;
    logic                     split_wide;
    logic                     retire_pause, res_we;
    logic [IDX_W-1:0]         retire_idx, rd_idx;
    logic [CMD_W-1:0]         rd_cmd;
    logic [RES_W-1:0]         res_data;

    // Queue spans from the split pointer.
    always_comb begin
        split_wide = split_ptr >= (IDX_W+1)'(ENTRIES);
        q_en       = {q2_en, q1_en};
        q_trig     = {q2_trig, q1_trig};
        q_start[0] = '0;
        q_end[0]   = split_wide ? IDX_W'(ENTRIES-1) : split_ptr[IDX_W-1:0] - IDX_W'(1);
        q_empty[0] = (split_ptr == '0);
        q_start[1] = split_ptr[IDX_W-1:0];
        q_end[1]   = IDX_W'(ENTRIES-1);
        q_empty[1] = split_wide;
        q_ready    = q_active & q_en;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        qseq_queue #(.IDX_W(IDX_W)) u_queue (
            .clk          (clk),
            .rst_n        (rst_n),
            .en           (q_en[g]),
            .trig         (q_trig[g]),
            .empty        (q_empty[g]),
            .start_idx    (q_start[g]),
            .end_idx      (q_end[g]),
            .retire       (retire[g]),
            .retire_pause (retire_pause),
            .retire_idx   (retire_idx),
            .active       (q_active[g]),
            .ptr          (q_ptr[g]),
            .pause_flag   (q_pflag[g]),
            .end_flag     (q_eflag[g])
        );
    end

    qseq_dispatch #(.IDX_W(IDX_W)) u_dispatch (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_ready      (q_ready),
        .q_ptr        (q_ptr),
        .rd_idx       (rd_idx),
        .rd_cmd       (cmd_t'(rd_cmd)),
        .cnv_done     (cnv_done),
        .cnv_result   (cnv_result),
        .cnv_req      (cnv_req),
        .cnv_chan     (cnv_chan),
        .cnv_stime    (cnv_stime),
        .grant        (grant),
        .retire       (retire),
        .retire_pause (retire_pause),
        .retire_idx   (retire_idx),
        .res_we       (res_we),
        .res_data     (res_data)
    );

    qseq_tables #(.ENTRIES(ENTRIES)) u_tables (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rd_idx     (rd_idx),
        .rd_cmd     (rd_cmd),
        .res_we     (res_we),
        .res_idx    (retire_idx),
        .res_data   (res_data)
    );

    assign q1_pause_flag = q_pflag[0];
    assign q2_pause_flag = q_pflag[1];
    assign q1_end_flag   = q_eflag[0];
    assign q2_end_flag   = q_eflag[1];

    // R7: at most one queue is granted per cycle.
    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: the high queue is never granted while the low queue is ready.
    p_low_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |-> !q_ready[0]);

    // R3: results are written only while a request is outstanding.
    p_result_on_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> cnv_req);
endmodule

// File: tb/conv_queue_seq_tb_top.sv
`timescale 1ns/1ps
module conv_queue_seq_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_we = 0;
    logic [6:0]  host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic        q1_en = 0, q2_en = 0, q1_trig = 0, q2_trig = 0;
    logic [6:0]  split_ptr = 0;
    logic        cnv_req;
    logic [5:0]  cnv_chan;
    logic [1:0]  cnv_stime;
    logic        cnv_done = 0;
    logic [9:0]  cnv_result = 0;
    logic        q1_pause_flag, q2_pause_flag, q1_end_flag, q2_end_flag;

    int nchecks = 0, nerr = 0;
    bit started = 0;

    always #2 clk = ~clk;

    conv_queue_seq dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .q1_en(q1_en),
        .q2_en(q2_en), .q1_trig(q1_trig), .q2_trig(q2_trig),
        .split_ptr(split_ptr), .cnv_req(cnv_req), .cnv_chan(cnv_chan),
        .cnv_stime(cnv_stime), .cnv_done(cnv_done), .cnv_result(cnv_result),
        .q1_pause_flag(q1_pause_flag), .q2_pause_flag(q2_pause_flag),
        .q1_end_flag(q1_end_flag), .q2_end_flag(q2_end_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cmd[64], m_res[64];
    bit mb;
    int mq, midx, mcmd;
    bit m_act[2], m_rok[2], m_pf[2], m_cf[2];
    int m_ptr[2], m_last[2];
    bit ret, rdy0, rdy1, en_q, tr_q;
    int rq, ridx, rpause;

    function automatic int q_start(int q);
        return (q == 0) ? 0 : int'(split_ptr) % 64;
    endfunction
    function automatic int q_end(int q);
        if (q == 1) return 63;
        return (split_ptr >= 64) ? 63 : int'(split_ptr) - 1;
    endfunction
    function automatic bit q_empty(int q);
        return (q == 0) ? (split_ptr == 0) : (split_ptr >= 64);
    endfunction
    function automatic int chan_of(int i);
        return m_cmd[i] & 63;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mb = 0; mq = 0; midx = 0; mcmd = 0;
            for (int i = 0; i < 64; i++) begin m_cmd[i] = 0; m_res[i] = 0; end
            for (int q = 0; q < 2; q++) begin
                m_act[q] = 0; m_rok[q] = 0; m_pf[q] = 0; m_cf[q] = 0; m_ptr[q] = 0; m_last[q] = 0;
            end
        end else begin
            rdy0 = m_act[0] && q1_en;
            rdy1 = m_act[1] && q2_en;
            ret = 0;
            if (mb && cnv_done) begin
                ret = 1; rq = mq; ridx = midx; rpause = (mcmd >> 9) & 1;
                m_res[midx] = int'(cnv_result); mb = 0;
            end else if (!mb && (rdy0 || rdy1)) begin
                mq = rdy0 ? 0 : 1; midx = m_ptr[mq]; mcmd = m_cmd[midx]; mb = 1;
            end
            for (int q = 0; q < 2; q++) begin
                en_q = (q == 0) ? q1_en : q2_en;
                tr_q = (q == 0) ? q1_trig : q2_trig;
                if (tr_q && en_q && !m_act[q] && !q_empty(q)) begin
                    m_act[q] = 1; m_pf[q] = 0; m_cf[q] = 0;
                    if (!m_rok[q]) m_ptr[q] = q_start(q);
                    m_rok[q] = 0;
                end
                if (ret && rq == q) begin
                    m_last[q] = ridx;
                    if (ridx == q_end(q)) begin
                        m_act[q] = 0; m_cf[q] = 1; m_rok[q] = 0;
                        if (rpause != 0) m_pf[q] = 1;
                    end else begin
                        m_ptr[q] = ridx + 1;
                        if (rpause != 0) begin m_act[q] = 0; m_pf[q] = 1; m_rok[q] = 1; end
                    end
                end
                if (!en_q) begin m_act[q] = 0; m_rok[q] = 0; end
            end
            if (host_we && !host_addr[6]) m_cmd[host_addr[5:0]] = int'(host_wdata[9:0]);
        end
    end

    // ---------------- per-cycle compare and converter model ----------------
    int wcnt = 0, lat = 1, nconv = 0;
    always @(negedge clk) begin
        if (rst_n && started) begin
            chk(cnv_req == mb, "R10 request", cnv_req, mb);
            if (mb) begin
                chk(int'(cnv_chan) == (mcmd & 63), "R2 channel", cnv_chan, mcmd & 63);
                chk(int'(cnv_stime) == ((mcmd >> 6) & 3), "R2 sample time", cnv_stime, (mcmd >> 6) & 3);
            end
            chk(q1_pause_flag == m_pf[0], "R6 low pause flag", q1_pause_flag, m_pf[0]);
            chk(q2_pause_flag == m_pf[1], "R6 high pause flag", q2_pause_flag, m_pf[1]);
            chk(q1_end_flag == m_cf[0], "R4 low end flag", q1_end_flag, m_cf[0]);
            chk(q2_end_flag == m_cf[1], "R5 high end flag", q2_end_flag, m_cf[1]);
        end
        if (cnv_done) begin
            cnv_done = 0;
        end else if (cnv_req) begin
            wcnt++;
            if (wcnt >= lat) begin
                cnv_done = 1;
                cnv_result = 10'((int'(cnv_chan) * 13 + nconv) & 1023);
                nconv++;
                wcnt = 0;
                lat = 1 + (nconv % 3);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse(input int q);
        @(negedge clk);
        if (q == 0) q1_trig = 1; else q2_trig = 1;
        @(negedge clk);
        q1_trig = 0; q2_trig = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!mb && !m_act[0] && !m_act[1] && !cnv_req) break;
        end
    endtask

    task automatic wait_new_req();
        for (int i = 0; i < 200 && cnv_req; i++) @(negedge clk);
        for (int i = 0; i < 200 && !cnv_req; i++) @(negedge clk);
    endtask

    task automatic host_wr(input int a, input int d);
        @(negedge clk);
        host_we = 1; host_addr = 7'(a); host_wdata = 16'(d);
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic host_rd(input int a, output int d);
        @(negedge clk);
        host_addr = 7'(a);
        #1 d = int'(host_rdata);
    endtask

    function automatic int pattern(int i);
        int p;
        p = ((i * 5 + 3) & 63) | ((i & 3) << 6) | ((i & 1) << 8);
        if (i == 3 || i == 40 || i == 50) p = p | (1 << 9);
        return p;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        int d;
        repeat (3) @(negedge clk);
        chk(cnv_req == 0, "R10 reset req", cnv_req, 0);
        chk({q1_pause_flag, q2_pause_flag, q1_end_flag, q2_end_flag} == 0, "R10 reset flags",
            {q1_pause_flag, q2_pause_flag, q1_end_flag, q2_end_flag}, 0);
        rst_n = 1;
        started = 1;

        for (int i = 0; i < 64; i++) host_wr(i, pattern(i) | 16'hFC00);
        host_rd(5, d);
        chk(d == pattern(5), "R1 masked readback", d, pattern(5));
        host_rd(9, d);
        chk((d >> 10) == 0, "R1 upper bits zero", d >> 10, 0);
        chk(((d >> 8) & 1) == 1, "R2 reserved bit kept", (d >> 8) & 1, 1);
        host_wr(64 + 5, 16'hFFFF);
        host_rd(64 + 5, d);
        chk(d == 0, "R3 result half not host-writable", d, 0);

        split_ptr = 8; q1_en = 1; q2_en = 1;
        pulse(0); wait_idle();
        chk(q1_pause_flag == 1, "R6 low queue paused at entry 3", q1_pause_flag, 1);
        pulse(0); wait_idle();
        chk(q1_end_flag == 1 && q1_pause_flag == 0, "R4 low queue end after resume",
            {q1_end_flag, q1_pause_flag}, 2);

        pulse(1);
        repeat (10) @(negedge clk);
        pulse(0);
        wait_new_req();
        chk(int'(cnv_chan) == chan_of(0), "R7 low queue preempts", cnv_chan, chan_of(0));
        for (int i = 0; i < 2000 && !q1_pause_flag; i++) @(negedge clk);
        wait_new_req();
        chk(int'(cnv_chan) == chan_of(m_last[1] + 1), "R7 high queue resumes next entry",
            cnv_chan, chan_of(m_last[1] + 1));
        wait_idle();
        chk(q2_pause_flag == 1, "R6 high queue paused at entry 40", q2_pause_flag, 1);
        pulse(1); wait_idle();
        pulse(1); wait_idle();
        chk(q2_end_flag == 1, "R5 high queue end", q2_end_flag, 1);
        pulse(0); wait_idle();
        pulse(0); wait_idle();

        q1_en = 0;
        pulse(0);
        repeat (8) @(negedge clk);
        chk(cnv_req == 0, "R9 disabled queue trigger ignored", cnv_req, 0);
        q1_en = 1; split_ptr = 0;
        pulse(0);
        repeat (8) @(negedge clk);
        chk(cnv_req == 0, "R9 empty low queue trigger ignored", cnv_req, 0);
        split_ptr = 64;
        pulse(1);
        repeat (8) @(negedge clk);
        chk(cnv_req == 0, "R9 empty high queue trigger ignored", cnv_req, 0);

        split_ptr = 8;
        pulse(1);
        repeat (6) @(negedge clk);
        q2_en = 0;
        wait_idle();
        q2_en = 1;
        pulse(1);
        wait_new_req();
        chk(int'(cnv_chan) == chan_of(8), "R11 restart from first entry", cnv_chan, chan_of(8));
        wait_idle();
        pulse(1); wait_idle();
        pulse(1); wait_idle();

        q2_en = 0; split_ptr = 64;
        for (int k = 0; k < 6 && !q1_end_flag; k++) begin pulse(0); wait_idle(); end
        chk(q1_end_flag == 1, "R4 whole table to low queue", q1_end_flag, 1);

        q1_en = 0; q2_en = 1; split_ptr = 0;
        for (int k = 0; k < 6 && !q2_end_flag; k++) begin pulse(1); wait_idle(); end
        chk(q2_end_flag == 1, "R5 whole table to high queue", q2_end_flag, 1);

        for (int i = 0; i < 64; i++) begin
            host_rd(64 + i, d);
            chk(d == m_res[i], "R3 result slot", d, m_res[i]);
            host_rd(i, d);
            chk(d == pattern(i), "R8 command table unchanged", d, pattern(i));
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule